// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block takes the symbols of one received Reed-Solomon codeword at a rate of one per clock. It evaluates the received polynomial at each of the 2t roots of the code generator. The symbol width, the field polynomial, the number of check symbols, the exponent of the first root and the spacing between root exponents are all elaboration parameters. The field polynomial is given as an integer: substitute x = 2 into it, so x^2+x+1 becomes 7. Codewords may be shorter than 2^s - 1 symbols. The block needs no length setting, because start-of-block and end-of-block strobes travel with the symbols.

Each syndrome lane keeps a Horner accumulator. The first symbol of a block clears the accumulator, and that first symbol is the coefficient of highest degree. Each lane multiplies by its own fixed root, and that multiplier is built inline. When the symbol that carries the end strobe is accepted, the syndrome vector and an "any syndrome nonzero" flag are registered. They are marked valid for one cycle. A downstream error solver uses the flag to pass a clean block through without correction.

The input follows valid/ready rules. The block never applies back-pressure, so `in_ready` is always high. A symbol counts only in a cycle with `in_valid` high. Gaps of any length between symbols are allowed. The result outputs are plain status signals and have no handshake.

Top module: `rs_syndrome_calc`

## Requirements
- R1: Lane j, found at `synd_vec[j*SYM_W +: SYM_W]`, equals the sum over i of r_i·β_j^(n-1-i), where β_j = α^(ROOTSPACE·(GSTART+j)). Here r_0 is the first symbol of the block, r_(n-1) is the last, and α is the root x of the field polynomial.
- R2: `FIELD_POLY` holds the field polynomial as its integer value at x = 2, with bit SYM_W set. All arithmetic is done modulo that polynomial.
- R3: A valid codeword of the configured generator gives an all-zero syndrome vector, with `synd_nonzero` = 0.
- R4: A codeword with 1 to NCHECK/2 corrupted symbols gives `synd_nonzero` = 1, and the vector follows R1.
- R5: Any block length from 1 to 2^SYM_W - 1 symbols is accepted. No length parameter is needed.
- R6: `synd_valid` is high in exactly the cycle after the edge that accepts a symbol with `in_last` set. `synd_vec` and `synd_nonzero` keep their values until the next such update.
- R7: `in_ready` is always 1. In a cycle with `in_valid` low, the data, `in_first` and `in_last` are ignored.
- R8: A block of one symbol, with `in_first` and `in_last` both set, gives every lane equal to that symbol.
- R9: During reset, `synd_valid`, `synd_vec` and `synd_nonzero` are all 0.
- R10: An accepted symbol with `in_first` set restarts every accumulator. Symbols of a block that was never ended have no effect on the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol present on `in_data` |
| in_ready | output | 1 | Always 1; the block accepts every cycle |
| in_data | input | SYM_W | Received symbol, highest degree first |
| in_first | input | 1 | Marks the first symbol of a block |
| in_last | input | 1 | Marks the last symbol of a block |
| synd_valid | output | 1 | One-cycle strobe: a new syndrome vector is present |
| synd_vec | output | NCHECK*SYM_W | Syndromes; lane j at bits j*SYM_W upward |
| synd_nonzero | output | 1 | Set when any syndrome of the last block is nonzero |

## Verification
The bench builds the block with 8-bit symbols and field polynomial 391. It uses 16 check symbols, a first root exponent of 112 and a root spacing of 11. The field polynomial differs from the default, and both root parameters are non-trivial, so a fault in the root-exponent arithmetic or in the field reduction cannot cancel out. With these values, full-length and shortened codewords are encoded in the bench and carry up to eight injected errors. The bench also covers one-symbol blocks, abandoned blocks and input gaps in which the strobes toggle.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;
  localparam int GF_MAXW = 12;
  typedef logic [GF_MAXW:0] gf_word_t;

  // multiply by x, reduce by the field polynomial
  function automatic gf_word_t gf_xtime(gf_word_t a, int w, int poly);
    gf_word_t t;
    t = a << 1;
    if (t[w]) t = t ^ gf_word_t'(poly);
    return t;
  endfunction

  // shift-and-add product, b scanned from its top bit
  function automatic gf_word_t gf_mul(gf_word_t a, gf_word_t b, int w, int poly);
    gf_word_t r;
    r = '0;
    for (int i = GF_MAXW - 1; i >= 0; i--) begin
      r = gf_xtime(r, w, poly);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // alpha^e by square and multiply
  function automatic gf_word_t gf_alpha_pow(int e, int w, int poly);
    gf_word_t r;
    r = gf_word_t'(1);
    for (int i = GF_MAXW; i >= 0; i--) begin
      r = gf_mul(r, r, w, poly);
      if (e[i]) r = gf_mul(r, gf_word_t'(2), w, poly);
    end
    return r;
  endfunction

  // root of syndrome lane j
  function automatic int gf_lane_root(int j, int w, int poly, int gstart, int rspace);
    int ord;
    int e;
    ord = (1 << w) - 1;
    e   = ((rspace % ord) * ((gstart + j) % ord)) % ord;
    return int'(gf_alpha_pow(e, w, poly));
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul #(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int CONST      = 1
) (
  input  logic [SYM_W-1:0] a,
  output logic [SYM_W-1:0] y
);
  import rs_syn_pkg::*;

  always_comb begin
    y = SYM_W'(gf_mul(gf_word_t'(a), gf_word_t'(CONST), SYM_W, FIELD_POLY));
  end
endmodule

// File: rtl/rs_syn_lane.sv
module rs_syn_lane #(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int ROOT       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] acc_nxt
);
  logic [SYM_W-1:0] acc;
  logic [SYM_W-1:0] base;
  logic [SYM_W-1:0] prod;

  always_comb base = restart ? '0 : acc;

  rs_gf_cmul #(
    .SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY), .CONST(ROOT)
  ) u_cmul (
    .a(base), .y(prod)
  );

  always_comb acc_nxt = prod ^ sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (take) acc <= acc_nxt;
  end
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int NCHECK     = 16,
  parameter int GSTART     = 0,
  parameter int ROOTSPACE  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SYM_W-1:0]        in_data,
  input  logic                    in_first,
  input  logic                    in_last,
  output logic                    synd_valid,
  output logic [NCHECK*SYM_W-1:0] synd_vec,
  output logic                    synd_nonzero
);
  localparam int VEC_W = NCHECK * SYM_W;

  logic             take;
  logic [VEC_W-1:0] nxt_vec;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  for (genvar j = 0; j < NCHECK; j++) begin : g_lane
    localparam int ROOT_J =
      rs_syn_pkg::gf_lane_root(j, SYM_W, FIELD_POLY, GSTART, ROOTSPACE);
    rs_syn_lane #(
      .SYM_W(SYM_W), .FIELD_POLY(FIELD_POLY), .ROOT(ROOT_J)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .restart (in_first),
      .sym     (in_data),
      .acc_nxt (nxt_vec[j*SYM_W +: SYM_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synd_valid   <= 1'b0;
      synd_vec     <= '0;
      synd_nonzero <= 1'b0;
    end else begin
      synd_valid <= take & in_last;
      if (take && in_last) begin
        synd_vec     <= nxt_vec;
        synd_nonzero <= |nxt_vec;
      end
    end
  end
endmodule

// File: rtl/rs_syn_chk.sv
module rs_syn_chk #(
  parameter int SYM_W  = 8,
  parameter int NCHECK = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [SYM_W-1:0]        in_data,
  input logic                    in_first,
  input logic                    in_last,
  input logic                    synd_valid,
  input logic [NCHECK*SYM_W-1:0] synd_vec,
  input logic                    synd_nonzero
);
  // R6
  a_r6_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid && in_ready && in_last) |-> synd_valid);
  // R6
  a_r6_valid_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    synd_valid |-> $past(in_valid && in_ready && in_last));
  // R6
  a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !synd_valid |-> $stable(synd_vec) && $stable(synd_nonzero));
  // R3 / R4
  a_r3_flag_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    synd_valid |-> (synd_nonzero == (synd_vec != '0)));
  // R8
  a_r8_single_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    synd_valid && $past(in_first) |-> synd_vec == {NCHECK{$past(in_data)}});
endmodule

bind rs_syndrome_calc rs_syn_chk #(.SYM_W(SYM_W), .NCHECK(NCHECK)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_first(in_first), .in_last(in_last),
  .synd_valid(synd_valid), .synd_vec(synd_vec), .synd_nonzero(synd_nonzero)
);

// File: tb/test_rs_syndrome_calc.sv
module test_rs_syndrome_calc;
  localparam int W = 8, POLY = 391, NC = 16, GS = 112, RSP = 11;
  localparam int VW = NC * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, synd_valid, synd_nonzero;
  logic [VW-1:0] synd_vec;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] cw [0:254];
  logic [W-1:0] gen [0:NC];
  logic [W-1:0] roots [0:NC-1];
  logic [VW-1:0] exp_vec;

  always #4 clk = ~clk;

  rs_syndrome_calc #(.SYM_W(W), .FIELD_POLY(POLY), .NCHECK(NC),
                     .GSTART(GS), .ROOTSPACE(RSP)) i_rs_syndrome_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .synd_valid(synd_valid), .synd_vec(synd_vec), .synd_nonzero(synd_nonzero));

  // carry-less product then reduction from the top
  function automatic logic [W-1:0] m_mul(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-2:0] p = '0;
    for (int i = 0; i < W; i++) if (b[i]) p = p ^ ((2*W-1)'(a) << i);
    for (int i = 2*W-2; i >= W; i--) if (p[i]) p = p ^ ((2*W-1)'(POLY) << (i - W));
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] m_pow(int e);
    logic [W-1:0] r = 1;
    for (int i = 0; i < e % 255; i++) r = m_mul(r, 8'd2);
    return r;
  endfunction

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // encode random message of length n into cw (systematic)
  task automatic encode(int n);
    logic [W-1:0] par [0:NC-1];
    logic [W-1:0] fb;
    for (int p = 0; p < NC; p++) par[p] = '0;
    for (int i = 0; i < n - NC; i++) begin
      cw[i] = W'($urandom);
      fb = cw[i] ^ par[NC-1];
      for (int p = NC - 1; p > 0; p--) par[p] = par[p-1] ^ m_mul(fb, gen[p]);
      par[0] = m_mul(fb, gen[0]);
    end
    for (int q = 0; q < NC; q++) cw[n - NC + q] = par[NC-1-q];
  endtask

  task automatic inject(int n, int ne);
    bit used [0:254];
    int pos;
    for (int i = 0; i < 255; i++) used[i] = 0;
    for (int e = 0; e < ne; e++) begin
      do pos = $urandom_range(n - 1); while (used[pos]);
      used[pos] = 1;
      cw[pos] = cw[pos] ^ W'($urandom_range(255, 1));
    end
  endtask

  // power-sum evaluation of cw at every root
  task automatic model(int n);
    logic [W-1:0] s, pw;
    for (int j = 0; j < NC; j++) begin
      s = '0; pw = 1;
      for (int i = n - 1; i >= 0; i--) begin
        s = s ^ m_mul(cw[i], pw);
        pw = m_mul(pw, roots[j]);
      end
      exp_vec[j*W +: W] = s;
    end
  endtask

  task automatic send(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 0; in_data = W'($urandom); in_first = 1; in_last = 1;
        @(negedge clk);
      end
      in_valid = 1; in_data = cw[i]; in_first = (i == 0); in_last = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic t_reset();
    chk("R9 valid", VW'(synd_valid), '0);
    chk("R9 vec", synd_vec, '0);
    chk("R9 flag", VW'(synd_nonzero), '0);
    chk("R7 ready", VW'(in_ready), VW'(1));
  endtask

  task automatic t_clean(); // R2 (poly 391), R3, R5 shortened lengths
    int lens [4] = '{255, 204, 100, 17};
    foreach (lens[k]) begin
      encode(lens[k]); send(lens[k], 0);
      chk("R6 valid", VW'(synd_valid), VW'(1));
      chk("R3 zero vec", synd_vec, '0);
      chk("R3 flag", VW'(synd_nonzero), '0);
    end
  endtask

  task automatic t_errors(); // R1, R4, R5
    int lens [3] = '{255, 204, 60};
    foreach (lens[k]) for (int ne = 1; ne <= NC / 2; ne++) begin
      encode(lens[k]); inject(lens[k], ne); model(lens[k]); send(lens[k], 0);
      chk("R1 syndromes", synd_vec, exp_vec);
      chk("R4 flag", VW'(synd_nonzero), VW'(1));
    end
  endtask

  task automatic t_gaps(); // R7
    encode(120); inject(120, 3); model(120); send(120, 1);
    chk("R7 gaps vec", synd_vec, exp_vec);
    chk("R7 gaps valid", VW'(synd_valid), VW'(1));
  endtask

  task automatic t_hold(); // R6
    logic [VW-1:0] held;
    encode(80); inject(80, 2); model(80); send(80, 0);
    held = synd_vec;
    for (int c = 0; c < 3; c++) begin
      in_valid = 0; in_last = 1; in_data = W'($urandom);
      @(negedge clk);
      chk("R6 one-cycle strobe", VW'(synd_valid), '0);
      chk("R6 held vec", synd_vec, held);
    end
    in_last = 0;
  endtask

  task automatic t_single(); // R8
    cw[0] = 8'hA5; send(1, 0);
    chk("R8 single", synd_vec, {NC{8'hA5}});
  endtask

  task automatic t_restart(); // R10
    for (int i = 0; i < 10; i++) begin
      in_valid = 1; in_data = W'($urandom); in_first = (i == 0); in_last = 0;
      @(negedge clk);
    end
    in_valid = 0;
    encode(90); inject(90, 4); model(90); send(90, 0);
    chk("R10 restart", synd_vec, exp_vec);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int j = 0; j < NC; j++) roots[j] = m_pow((RSP * (GS + j)) % 255);
    for (int i = 0; i <= NC; i++) gen[i] = '0;
    gen[0] = 1;
    for (int j = 0; j < NC; j++) begin
      for (int i = j + 1; i > 0; i--) gen[i] = gen[i-1] ^ m_mul(gen[i], roots[j]);
      gen[0] = m_mul(gen[0], roots[j]);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_clean();
    t_errors();
    t_gaps();
    t_hold();
    t_single();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule